// File: doc/BRIEF.md
# Trace Memory Pairwise Peak Compressor

This block owns a single-port trace RAM, by default 1024 words of 8 bits, and the sequencer that addresses it. Time is divided into phases. Each pulse of a phase enable ends the current phase, and read phases alternate with write phases.

In normal operation an acquisition source writes one sample per write phase. During a read phase, the word at the acquisition address is visible on the read-data output.

When a store request is raised, the block makes one compress pass over the whole memory. A single comparator and a one-word latch run across consecutive addresses. Write phases always address the even member of the current pair. As a result, every even location ends up holding the larger value of its pair, and no second buffer is needed. After the pass, the block stays in a hold mode for as long as the request remains high. In hold mode, acquisition writes are steered to odd locations only, which keeps the compressed trace intact.

Top module: `peak_store_ctrl`

## Requirements
- R1: After reset the block is idle and in a read phase: `wr_phase`=0, `done_o`=0, `hold_o`=0.
- R2: Each cycle with `ph_en`=1 toggles the phase, where `wr_phase`=1 means write phase. With `ph_en`=0 the phase holds. RAM writes take effect only at a write-phase edge with `ph_en`=1.
- R3: In idle, every write phase with `ph_en`=1 writes `acq_data` to `acq_addr` without condition. In read phases, in any mode other than a pass, `rd_data` shows the word at `acq_addr`.
- R4: A pass starts when `store_req`=1 at the end of a write phase in idle. One priming read loads address 0 into the latch. The counter then steps from 1 to 1023, incrementing at the start of each read phase. During a pass, every write-phase address has bit 0 forced to 0.
- R5: During a pass, a read phase raises the write flag only when the current word is strictly greater than the latched word, then loads the current word into the latch. The next write phase stores the latch at the even address, or writes nothing if the flag is clear. After the pass, each even address 2k holds max(orig[2k], orig[2k+1]) and each odd address is unchanged.
- R6: `done_o` rises on the 2049th `ph_en` step counted from the step that starts the pass. It falls at the next `ph_en` step.
- R7: In hold mode, an acquisition write to `acq_addr` lands at `acq_addr` with bit 0 forced to 1. Reads use `acq_addr` unmodified.
- R8: In hold mode, `store_req`=0 returns the block to idle on the next clock, which releases the bit-0 forcing.
- R9: Changes of `store_req` while a pass runs are ignored. The pass completes with unchanged timing and result.
- R10: `hold_o` is 1 from the end of the pass until hold mode is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ph_en | input | 1 | phase enable; ends the current phase |
| store_req | input | 1 | request a compress pass, then hold |
| acq_addr | input | ADDR_W | acquisition address |
| acq_data | input | DATA_W | acquisition sample |
| rd_data | output | DATA_W | RAM data output |
| wr_phase | output | 1 | 1 during a write phase |
| done_o | output | 1 | pass-complete pulse, one phase long |
| hold_o | output | 1 | hold mode active |

## Verification
The assertions check several rules on every cycle. Pass writes must target even addresses and hold writes odd ones. Writes must fall only in write phases. The phase must toggle exactly on enable pulses. The done pulse must last one phase, and a dropped request must leave hold. Only the scenarios can show the data result of a pass: each even word becoming the pair maximum, ties leaving memory untouched, and odd words surviving. The scenarios also cover the exact completion step and the tolerance of request toggles during a pass.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_PASS  = 2'd2,
        ST_HOLD  = 2'd3
    } psc_state_e;
endpackage

// File: rtl/psc_trace_ram.sv
module psc_trace_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              we,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= din;
    end

    assign dout = mem[addr];
endmodule

// File: rtl/psc_seq.sv
module psc_seq
    import psc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph_en,
    input  logic              store_req,
    input  logic [DATA_W-1:0] ram_dout,
    output psc_state_e        state,
    output logic              wr_ph,
    output logic [ADDR_W-1:0] cnt,
    output logic [DATA_W-1:0] latch,
    output logic              we_flag,
    output logic              done
);
    localparam logic [ADDR_W-1:0] CNT_LAST = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] CNT_ONE  = ADDR_W'(1);

    typedef struct packed {
        psc_state_e        st;
        logic              wr;
        logic [ADDR_W-1:0] cnt;
        logic [DATA_W-1:0] latch;
        logic              wef;
        logic              done;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (ph_en) begin
            r_d.done = 1'b0;
            if (!r_q.wr) begin
                r_d.wr = 1'b1;
                if (r_q.st == ST_PRIME || r_q.st == ST_PASS) begin
                    r_d.latch = ram_dout;
                    r_d.wef   = (r_q.st == ST_PASS) && (ram_dout > r_q.latch);
                end
            end else begin
                r_d.wr = 1'b0;
                case (r_q.st)
                    ST_IDLE: begin
                        if (store_req) begin
                            r_d.st  = ST_PRIME;
                            r_d.cnt = '0;
                        end
                    end
                    ST_PRIME: begin
                        r_d.st  = ST_PASS;
                        r_d.cnt = CNT_ONE;
                    end
                    ST_PASS: begin
                        if (r_q.cnt == CNT_LAST) begin
                            r_d.st   = ST_HOLD;
                            r_d.cnt  = '0;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.cnt = r_q.cnt + CNT_ONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
        if (r_q.st == ST_HOLD && !store_req) r_d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, wr: 1'b0, cnt: '0, latch: '0, wef: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state   = r_q.st;
    assign wr_ph   = r_q.wr;
    assign cnt     = r_q.cnt;
    assign latch   = r_q.latch;
    assign we_flag = r_q.wef;
    assign done    = r_q.done;
endmodule

// File: rtl/psc_addr_mux.sv
module psc_addr_mux
    import psc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  psc_state_e        state,
    input  logic              wr_ph,
    input  logic              ph_en,
    input  logic [ADDR_W-1:0] cnt,
    input  logic [DATA_W-1:0] latch,
    input  logic              we_flag,
    input  logic [ADDR_W-1:0] acq_addr,
    input  logic [DATA_W-1:0] acq_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_din,
    output logic              ram_we
);
    logic allow;

    always_comb begin
        ram_addr = acq_addr;
        ram_din  = acq_data;
        allow    = 1'b1;
        case (state)
            ST_PRIME: begin
                ram_addr = wr_ph ? {cnt[ADDR_W-1:1], 1'b0} : cnt;
                allow    = 1'b0;
            end
            ST_PASS: begin
                ram_addr = wr_ph ? {cnt[ADDR_W-1:1], 1'b0} : cnt;
                ram_din  = latch;
                allow    = we_flag;
            end
            ST_HOLD: begin
                if (wr_ph) ram_addr = {acq_addr[ADDR_W-1:1], 1'b1};
            end
            default: ;
        endcase
        ram_we = wr_ph && ph_en && allow;
    end
endmodule

// File: rtl/peak_store_ctrl.sv
module peak_store_ctrl
    import psc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph_en,
    input  logic              store_req,
    input  logic [ADDR_W-1:0] acq_addr,
    input  logic [DATA_W-1:0] acq_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_phase,
    output logic              done_o,
    output logic              hold_o
);
    psc_state_e        state;
    logic [ADDR_W-1:0] cnt;
    logic [DATA_W-1:0] latch;
    logic              we_flag;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_din;
    logic [DATA_W-1:0] ram_dout;
    logic              ram_we;
    logic              pass_act;

    psc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph_en    (ph_en),
        .store_req(store_req),
        .ram_dout (ram_dout),
        .state    (state),
        .wr_ph    (wr_phase),
        .cnt      (cnt),
        .latch    (latch),
        .we_flag  (we_flag),
        .done     (done_o)
    );

    psc_addr_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .state   (state),
        .wr_ph   (wr_phase),
        .ph_en   (ph_en),
        .cnt     (cnt),
        .latch   (latch),
        .we_flag (we_flag),
        .acq_addr(acq_addr),
        .acq_data(acq_data),
        .ram_addr(ram_addr),
        .ram_din (ram_din),
        .ram_we  (ram_we)
    );

    psc_trace_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk (clk),
        .addr(ram_addr),
        .din (ram_din),
        .we  (ram_we),
        .dout(ram_dout)
    );

    assign rd_data  = ram_dout;
    assign hold_o   = (state == ST_HOLD);
    assign pass_act = (state == ST_PASS);
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ph_en,
    input logic              store_req,
    input logic              wr_phase,
    input logic              done_o,
    input logic              hold_o,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              pass_act
);
    a_r2_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ph_en |=> (wr_phase != $past(wr_phase)));

    a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_en |=> $stable(wr_phase));

    a_r2_write_in_wr_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (wr_phase && ph_en));

    a_r4_pass_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && pass_act) |-> !ram_addr[0]);

    a_r7_hold_odd_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && hold_o) |-> ram_addr[0]);

    a_r6_done_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ph_en) |=> !done_o);

    a_r8_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !store_req) |=> !hold_o);

    a_r10_done_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> hold_o);
endmodule

bind peak_store_ctrl psc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph_en    (ph_en),
    .store_req(store_req),
    .wr_phase (wr_phase),
    .done_o   (done_o),
    .hold_o   (hold_o),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .pass_act (pass_act)
);

// File: tb/sim_peak_store_ctrl.sv
module sim_peak_store_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int DONE_STEP = 2049;
    localparam int NVEC = 4;
    // {kind, seed}
    localparam logic [15:0] VEC [NVEC] = '{16'h0025, 16'h0100, 16'h0200, 16'h0309};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ph_en = 1'b0;
    logic          store_req = 1'b0;
    logic [AW-1:0] acq_addr = '0;
    logic [DW-1:0] acq_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_phase, done_o, hold_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] orig  [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    peak_store_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ph_en(ph_en), .store_req(store_req),
        .acq_addr(acq_addr), .acq_data(acq_data), .rd_data(rd_data),
        .wr_phase(wr_phase), .done_o(done_o), .hold_o(hold_o)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: act=timeout exp=finished");
        summary();
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [DW-1:0] pat(input int kind, input int seed, input int i);
        int v;
        case (kind)
            0: v = i * seed + (i >> 3);
            1: v = 8'h55;
            2: v = (i % 2 == 1) ? 200 - (i % 50) : 10 + (i % 40);
            default: v = (i % 2 == 1) ? seed : 250 - (i % 60);
        endcase
        return v[DW-1:0];
    endfunction

    // idle write: commits at the end of the next write phase
    task automatic wr_word(input int a, input logic [DW-1:0] d);
        if (!wr_phase) tick();
        acq_addr = AW'(a);
        acq_data = d;
        tick();
        model[a] = d;
    endtask

    // read through the acquisition port; write phases rewrite the model value
    task automatic rd_word(input int a, input bit hold, output logic [DW-1:0] v);
        int t;
        t = hold ? (a | 1) : a;
        acq_addr = AW'(a);
        acq_data = model[t];
        if (wr_phase) tick();
        #1;
        v = rd_data;
    endtask

    task automatic run_pass(input bit toggle_req);
        int n;
        if (!wr_phase) tick();
        store_req = 1'b1;
        n = 0;
        while (n < 3000) begin
            tick();
            n++;
            if (toggle_req && n == 100) store_req = 1'b0;
            if (toggle_req && n == 200) store_req = 1'b1;
            if (done_o) break;
        end
        chk(toggle_req ? "R9 done step with toggled request" : "R6 done step", n, DONE_STEP);
        chk("R10 hold after pass", int'(hold_o), 1);
        tick();
        chk("R6 done falls next step", int'(done_o), 0);
        for (int i = 0; i < DEPTH; i += 2) begin
            model[i] = (orig[i + 1] > orig[i]) ? orig[i + 1] : orig[i];
        end
    endtask

    initial begin
        logic [DW-1:0] v;
        logic          ph0;
        int            kind, seed, bad;
        ph_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 wr_phase", int'(wr_phase), 0);
        chk("R1 done_o", int'(done_o), 0);
        chk("R1 hold_o", int'(hold_o), 0);
        acq_addr = '0;
        acq_data = '0;
        model[0] = '0;
        rst_n = 1'b1;
        #1;
        chk("R1 wr_phase after release", int'(wr_phase), 0);
        // R2 phase toggles and holds
        ph0 = wr_phase;
        tick();
        chk("R2 toggle", int'(wr_phase), int'(!ph0));
        ph_en = 1'b0;
        ph0 = wr_phase;
        tick(); tick();
        chk("R2 hold without enable", int'(wr_phase), int'(ph0));
        ph_en = 1'b1;

        for (int vi = 0; vi < NVEC; vi++) begin
            kind = int'(VEC[vi][15:8]);
            seed = int'(VEC[vi][7:0]);
            for (int i = 0; i < DEPTH; i++) begin
                orig[i] = pat(kind, seed, i);
                wr_word(i, orig[i]);
            end
            // R3 idle readback
            rd_word(5, 1'b0, v);
            chk("R3 idle readback", int'(v), int'(orig[5]));
            run_pass(vi == 1);
            bad = 0;
            for (int i = 0; i < DEPTH; i++) begin
                rd_word(i, 1'b1, v);
                if (v != model[i]) begin
                    bad++;
                    $display("FAIL R5 vec%0d addr %0d: act=%0d exp=%0d", vi, i, v, model[i]);
                end
            end
            n_chk++;
            if (bad != 0) n_bad++;
            if (vi == 3) begin
                // R7 hold write to an even address lands on the odd neighbour
                if (!wr_phase) begin
                    acq_addr = AW'(41);
                    acq_data = model[41];
                    tick();
                end
                acq_addr = AW'(40);
                acq_data = 8'hA7;
                tick();
                model[41] = 8'hA7;
                rd_word(40, 1'b1, v);
                chk("R7 even kept in hold", int'(v), int'(model[40]));
                rd_word(41, 1'b1, v);
                chk("R7 odd written in hold", int'(v), 32'hA7);
            end
            store_req = 1'b0;
            tick();
            chk("R8 hold left", int'(hold_o), 0);
            if (vi == 3) begin
                wr_word(40, 8'h3C);
                rd_word(40, 1'b0, v);
                chk("R8 even writable after release", int'(v), 32'h3C);
            end
        end
        summary();
    end
endmodule